// File: doc/BRIEF.md
# External Interrupt Flag Controller

This block turns a set of active-low external interrupt pins into registered interrupt request flags for a small microcontroller-style interrupt system. Each pin is brought into the clock domain through a synchronizer. A per-input sense-type bit then decides how that input's flag behaves. With the bit set, a falling edge latches the flag. With the bit clear, the flag tracks the pin's low level.

The flags drive the interrupt request outputs directly. Interrupt entry is reported to the block as a one-cycle acknowledge per input. In edge mode the acknowledge clears the flag. In level mode it is ignored, so the request stays up until the pin goes high again or software clears it. Software can load the sense-type bits together and can write each flag on its own.

The default build has two inputs. The input count and synchronizer depth are parameters.

Top module: `ext_irq_flags`

## Requirements
- R1: While `rst` is high at a clock edge, every bit of `irq_req` and `irq_type` reads 0 after that edge. The synchronizers reset to the idle-high state, so leaving reset with a pin high raises no flag.
- R2: A cycle with `type_wr` high loads `type_wdata` into `irq_type` at that edge. Bit i = 1 selects falling-edge sensing for input i, and bit i = 0 selects low-level sensing.
- R3: In edge mode, a pin that goes from 1 to 0 and stays low sets its flag on the third rising clock edge after the change. The flag stays set after the pin returns high. A rising pin never sets the flag.
- R4: In edge mode, an `ack` bit sampled high clears that input's flag at the same edge, unless a new falling edge is setting it.
- R5: In level mode, the flag equals the inverted pin, delayed by three clock edges, on every cycle without a software write. An `ack` in level mode leaves the flag unchanged.
- R6: A cycle with `flag_wr[i]` high loads `flag_wdata[i]` into flag i at that edge, in either mode. In level mode the following cycles resume tracking the pin.
- R7: In edge mode, when a falling edge is detected in the same cycle as an `ack` or a software write of 0, the flag is set, so no edge is lost.
- R8: Inputs are independent. Pin, acknowledge and write activity on one input never changes another input's flag.
- R9: In edge mode, a pin held low sets the flag only once. After an acknowledge, the flag stays clear until the pin rises and falls again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_n | input | NUM_INPUTS | Asynchronous active-low interrupt pins |
| type_wr | input | 1 | Write strobe for the sense-type bits |
| type_wdata | input | NUM_INPUTS | New sense-type bits (1 = falling edge, 0 = low level) |
| ack | input | NUM_INPUTS | Per-input interrupt-entry acknowledge pulse |
| flag_wr | input | NUM_INPUTS | Per-input software flag write strobe |
| flag_wdata | input | NUM_INPUTS | Per-input software flag value |
| irq_req | output | NUM_INPUTS | Registered interrupt request flags |
| irq_type | output | NUM_INPUTS | Current sense-type bits |

## Verification
The flags are the only state visible at the ports. An error in the synchronizer or in the stored previous pin sample therefore shows up as a flag that rises a cycle early or late, rises on a rising pin, or rises again while the pin is held low. All of these appear within three clock edges of the pin change. A wrong priority between set, acknowledge and software write shows up on the edge right after the collision, where the flag reads 0 instead of 1. Crosstalk between inputs shows up as an unexpected change in the other input's flag in the same cycle.

// File: rtl/eif_pkg.sv
package eif_pkg;

  // Software and service-entry controls for one input channel.
  typedef struct packed {
    logic ack;    // interrupt-entry acknowledge
    logic wr;     // software flag write strobe
    logic wdata;  // software flag value
  } eif_ctl_t;

  // Sense-type encoding of one type bit.
  typedef enum logic {
    SENSE_LEVEL = 1'b0,
    SENSE_EDGE  = 1'b1
  } eif_sense_e;

endpackage

// File: rtl/eif_sync.sv
module eif_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_n,
  output logic cur,   // synchronized pin
  output logic prev   // synchronized pin one cycle earlier
);
  localparam int CHAIN_W = STAGES + 1;

  logic [CHAIN_W-1:0] chain;

  // Preloaded high so that leaving reset never looks like a falling edge.
  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= {chain[CHAIN_W-2:0], pin_n};
  end

  assign cur  = chain[STAGES-1];
  assign prev = chain[STAGES];

  initial begin
    assert (STAGES >= 2) else $error("eif_sync: STAGES below 2");
  end
endmodule

// File: rtl/eif_type_reg.sv
module eif_type_reg #(
  parameter int NUM_INPUTS = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr,
  input  logic [NUM_INPUTS-1:0] wdata,
  output logic [NUM_INPUTS-1:0] sense
);
  always_ff @(posedge clk) begin
    if (rst)     sense <= '0;
    else if (wr) sense <= wdata;
  end

  p_type_load_r2: assert property (@(posedge clk) disable iff (rst)
    wr |=> (sense == $past(wdata)));

  p_type_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!wr && !$past(rst)) |=> $stable(sense));
endmodule

// File: rtl/eif_channel.sv
module eif_channel
  import eif_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     sense,    // eif_sense_e encoding
  input  logic     s_cur,
  input  logic     s_prev,
  input  eif_ctl_t ctl,
  output logic     flag
);
  logic edge_mode;
  logic fall;
  logic flag_nxt;

  assign edge_mode = (sense == SENSE_EDGE);
  assign fall      = s_prev & ~s_cur;

  always_comb begin
    flag_nxt = flag;
    if (edge_mode) begin
      // Priority: new edge, then software write, then acknowledge.
      if (fall)         flag_nxt = 1'b1;
      else if (ctl.wr)  flag_nxt = ctl.wdata;
      else if (ctl.ack) flag_nxt = 1'b0;
    end else begin
      // Level sensing: the acknowledge has no effect here.
      if (ctl.wr) flag_nxt = ctl.wdata;
      else        flag_nxt = ~s_cur;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) flag <= 1'b0;
    else     flag <= flag_nxt;
  end

  p_edge_sets_r3: assert property (@(posedge clk) disable iff (rst)
    (edge_mode && fall) |=> flag);

  p_edge_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (edge_mode && !fall && !ctl.wr && !ctl.ack) |=> $stable(flag));

  p_ack_clears_r4: assert property (@(posedge clk) disable iff (rst)
    (edge_mode && ctl.ack && !ctl.wr && !fall) |=> !flag);

  p_level_track_r5: assert property (@(posedge clk) disable iff (rst)
    (!edge_mode && !ctl.wr) |=> (flag == !$past(s_cur)));

  p_sw_write_r6: assert property (@(posedge clk) disable iff (rst)
    (ctl.wr && !(edge_mode && fall)) |=> (flag == $past(ctl.wdata)));
endmodule

// File: rtl/ext_irq_flags.sv
module ext_irq_flags
  import eif_pkg::*;
#(
  parameter int NUM_INPUTS  = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_INPUTS-1:0] pin_n,
  input  logic                  type_wr,
  input  logic [NUM_INPUTS-1:0] type_wdata,
  input  logic [NUM_INPUTS-1:0] ack,
  input  logic [NUM_INPUTS-1:0] flag_wr,
  input  logic [NUM_INPUTS-1:0] flag_wdata,
  output logic [NUM_INPUTS-1:0] irq_req,
  output logic [NUM_INPUTS-1:0] irq_type
);
  logic [NUM_INPUTS-1:0] s_cur;
  logic [NUM_INPUTS-1:0] s_prev;

  eif_type_reg #(.NUM_INPUTS(NUM_INPUTS)) u_type (
    .clk   (clk),
    .rst   (rst),
    .wr    (type_wr),
    .wdata (type_wdata),
    .sense (irq_type)
  );

  for (genvar i = 0; i < NUM_INPUTS; i++) begin : g_in
    eif_ctl_t ctl;
    assign ctl = '{ack: ack[i], wr: flag_wr[i], wdata: flag_wdata[i]};

    eif_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst   (rst),
      .pin_n (pin_n[i]),
      .cur   (s_cur[i]),
      .prev  (s_prev[i])
    );

    eif_channel u_chan (
      .clk    (clk),
      .rst    (rst),
      .sense  (irq_type[i]),
      .s_cur  (s_cur[i]),
      .s_prev (s_prev[i]),
      .ctl    (ctl),
      .flag   (irq_req[i])
    );
  end

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (irq_req == '0 && irq_type == '0));
endmodule

// File: tb/ext_irq_flags_test.sv
module ext_irq_flags_test;
  localparam int N = 2;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] pin_n = '1;
  logic         type_wr = 1'b0;
  logic [N-1:0] type_wdata = '0;
  logic [N-1:0] ack = '0;
  logic [N-1:0] flag_wr = '0;
  logic [N-1:0] flag_wdata = '0;
  logic [N-1:0] irq_req;
  logic [N-1:0] irq_type;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ext_irq_flags #(.NUM_INPUTS(N), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst(rst), .pin_n(pin_n), .type_wr(type_wr),
    .type_wdata(type_wdata), .ack(ack), .flag_wr(flag_wr),
    .flag_wdata(flag_wdata), .irq_req(irq_req), .irq_type(irq_type)
  );

  // Advance past n rising edges; drive and sample 1 ns after the edge.
  task automatic step(input int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic set_types(input logic [N-1:0] t);
    type_wr = 1'b1; type_wdata = t;
    step();
    type_wr = 1'b0;
  endtask

  task automatic sw_write(input int ch, input logic v);
    flag_wr[ch] = 1'b1; flag_wdata[ch] = v;
    step();
    flag_wr[ch] = 1'b0; flag_wdata[ch] = 1'b0;
  endtask

  task automatic pulse_ack(input int ch);
    ack[ch] = 1'b1;
    step();
    ack[ch] = 1'b0;
  endtask

  task automatic t_reset();
    step(3);
    check("R1 reset flags", irq_req, 2'b00);
    check("R1 reset types", irq_type, 2'b00);
    rst = 1'b0;
    step(4);
    check("R1 no flag after reset, pins high", irq_req, 2'b00);
  endtask

  task automatic t_types();
    set_types(2'b10);
    check("R2 type load", irq_type, 2'b10);
    set_types(2'b01);
    check("R2 type reload", irq_type, 2'b01);
  endtask

  // Input 0 edge mode, input 1 level mode (types = 01).
  task automatic t_edge();
    pin_n[0] = 1'b0;
    step(2);
    check("R3 not yet set after two edges", irq_req, 2'b00);
    step();
    check("R3 set on third edge; R8 input 1 untouched", irq_req, 2'b01);
    pin_n[0] = 1'b1;
    step(5);
    check("R3 flag held after pin rises", irq_req, 2'b01);
    pulse_ack(0);
    check("R4 ack clears edge flag", irq_req, 2'b00);
    step(4);
    check("R3 rising pin does not set", irq_req, 2'b00);
  endtask

  task automatic t_held_low();
    pin_n[0] = 1'b0;
    step(3);
    check("R9 first set", irq_req, 2'b01);
    pulse_ack(0);
    check("R9 cleared by ack", irq_req, 2'b00);
    step(6);
    check("R9 held low does not re-set", irq_req, 2'b00);
    pin_n[0] = 1'b1;
    step(3);
    pin_n[0] = 1'b0;
    step(3);
    check("R9 new edge sets again", irq_req, 2'b01);
    pin_n[0] = 1'b1;
    step(3);
    sw_write(0, 1'b0);
    check("R6 edge-mode write 0 clears", irq_req, 2'b00);
  endtask

  task automatic t_level();
    pin_n[1] = 1'b0;
    step(2);
    check("R5 level not yet visible", irq_req, 2'b00);
    step();
    check("R5 level flag follows low pin; R8 input 0 untouched", irq_req, 2'b10);
    pulse_ack(1);
    check("R5 ack ignored in level mode", irq_req, 2'b10);
    step(2);
    check("R5 still set after ack", irq_req, 2'b10);
    pin_n[1] = 1'b1;
    step(2);
    check("R5 flag still set two edges after rise", irq_req, 2'b10);
    step();
    check("R5 flag drops on third edge after rise", irq_req, 2'b00);
  endtask

  task automatic t_sw();
    sw_write(0, 1'b1);
    check("R6 edge-mode write 1 sets", irq_req, 2'b01);
    step(3);
    check("R6 edge-mode written flag held", irq_req, 2'b01);
    sw_write(0, 1'b0);
    check("R6 edge-mode write 0 clears", irq_req, 2'b00);
    sw_write(1, 1'b1);
    check("R6 level-mode write 1 visible one cycle", irq_req, 2'b10);
    step();
    check("R6 level-mode resumes tracking high pin", irq_req, 2'b00);
  endtask

  task automatic t_race();
    // Fall detected in the cycle ending at the third edge; ack lands there.
    pin_n[0] = 1'b0;
    step(2);
    ack[0] = 1'b1;
    step();
    ack[0] = 1'b0;
    check("R7 edge wins over ack", irq_req, 2'b01);
    pin_n[0] = 1'b1;
    step(3);
    sw_write(0, 1'b0);
    check("R6 clear before second race", irq_req, 2'b00);
    pin_n[0] = 1'b0;
    step(2);
    flag_wr[0] = 1'b1; flag_wdata[0] = 1'b0;
    step();
    flag_wr[0] = 1'b0;
    check("R7 edge wins over software clear", irq_req, 2'b01);
    pin_n[0] = 1'b1;
    step(3);
    sw_write(0, 1'b0);
  endtask

  task automatic t_both_edge();
    set_types(2'b11);
    pin_n = 2'b00;
    step(3);
    check("R8 both edge flags set", irq_req, 2'b11);
    pin_n = 2'b11;
    pulse_ack(1);
    check("R8 ack on input 1 leaves input 0", irq_req, 2'b01);
    pulse_ack(0);
    check("R4 ack input 0 clears", irq_req, 2'b00);
  endtask

  initial begin
    step();
    t_reset();
    t_types();
    t_edge();
    t_held_low();
    t_level();
    t_sw();
    t_race();
    t_both_edge();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 100000; k++) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule